// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Phase Offset

The block turns a fast input clock into a periodic one-cycle enable pulse at a programmable fraction of its rate. The ratio runs from 1 to 8. The first pulse after a restart can be pushed back by 0 to 7 whole input cycles. Alongside the enable, the block produces a registered divided clock with a near-even duty cycle, and a flag that asks for duty-cycle stabilisation whenever the block is actually dividing.

Software-facing logic presents new ratio and phase codes on the code inputs. The codes act only when the apply strobe is pulsed. Each apply also restarts the divider, and so does a separate sync pulse. This lets several dividers be aligned to a common event, each at its own phase.

Top module: `clkdiv_phase`

## Requirements
- R1: With an active ratio code c, the enable repeats every c+1 input cycles once the phase delay has elapsed, so code 000 gives divide by 1 and code 111 gives divide by 8.
- R2: After a restart edge, the first enable is seen P cycles after the cycle that follows that edge, where P is the active 3-bit phase code (000 = no delay, 111 = 7 cycles).
- R3: `stab_active_o` is high exactly when the active ratio code is not 000.
- R4: After reset, both active codes are 000: the enable is high on every cycle, the divided clock is high and the stabiliser flag is low.
- R5: Changes on `ratio_code_i` or `phase_code_i` without `apply_i` have no effect on any output.
- R6: A `sync_i` pulse restarts the divider with the current codes. An `apply_i` pulse loads both codes and restarts the divider on the same edge.
- R7: With ratio code 000, the enable stays high on every cycle once the delay has elapsed.
- R8: `div_clk_o` is high for the first ceil(N/2) cycles of each N-cycle period, low for the rest of the period, and low throughout the phase delay.
- R9: After an apply with phase P > 0, the enable and divided clock stay low for P cycles, so no shortened pulse from the old setting appears.
- R10: If `sync_i` and `apply_i` arrive together, a single restart takes place and uses the newly applied codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_code_i | input | 3 | Pending ratio code (divide by code+1) |
| phase_code_i | input | 3 | Pending phase delay in input cycles |
| apply_i | input | 1 | Loads the pending codes and restarts |
| sync_i | input | 1 | Restarts the divider with the active codes |
| div_en_o | output | 1 | One-cycle enable at each divided period start |
| div_clk_o | output | 1 | Registered divided clock |
| stab_active_o | output | 1 | High when the active ratio is above 1 |

## Verification
The bench aims at the following corner cases, and a defect in each shows up as follows:
- **Apply partway through a period.** A divider that fails to restart on apply would leave a runt pulse or a stretched first period.
- **Apply and sync on the same edge.** A divider that lets sync win here would keep running with the stale codes.
- **Code changes without apply.** A divider that follows such changes would shift its period with no strobe.
- **Odd ratios.** An error in rounding the high time would make `div_clk_o` one cycle short.
- **Divide by 1 with a non-zero phase.** A counter that wraps wrongly here would drop the enable to every other cycle.

A sweep over all 64 code pairs compares every cycle against an age-since-restart model. This catches off-by-one errors in the delay count and in the period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CODE_W_DEF = 3;

  // high-time length for a ratio code: ceil((code+1)/2)
  function automatic int unsigned high_len(input int unsigned code);
    return (code + 2) / 2;
  endfunction
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic [CODE_W-1:0] phase_code_i,
  input  logic              apply_i,
  input  logic              sync_i,
  output logic [CODE_W-1:0] ratio_o,
  output logic [CODE_W-1:0] ratio_nx_o,
  output logic [CODE_W-1:0] load_phase_o,
  output logic              restart_o,
  output logic              stab_o
);
  logic [CODE_W-1:0] ratio_q, phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      phase_q <= '0;
    end else if (apply_i) begin
      ratio_q <= ratio_code_i;
      phase_q <= phase_code_i;
    end
  end

  assign ratio_o      = ratio_q;
  assign ratio_nx_o   = apply_i ? ratio_code_i : ratio_q;
  assign load_phase_o = apply_i ? phase_code_i : phase_q;
  assign restart_o    = apply_i | sync_i;
  assign stab_o       = (ratio_q != '0);

  // R5
  hold_without_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(ratio_q) && $stable(phase_q));
endmodule

// File: rtl/clkdiv_delay.sv
module clkdiv_delay #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] load_i,
  output logic              zero_o,
  output logic              zero_nx_o
);
  logic [CODE_W-1:0] dly_q, dly_d;

  always_comb begin
    if (restart_i)         dly_d = load_i;
    else if (dly_q != '0)  dly_d = dly_q - 1'b1;
    else                   dly_d = dly_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= dly_d;
  end

  assign zero_o    = (dly_q == '0);
  assign zero_nx_o = (dly_d == '0);

  // R2
  delay_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> dly_q == $past(load_i));

  // R2
  delay_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && dly_q != '0) |=> dly_q == $past(dly_q) - 1'b1);
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] ratio_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic [CODE_W-1:0] cnt_nx_o
);
  logic [CODE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i)  cnt_d = '0;
    else if (adv_i) cnt_d = (cnt_q == ratio_i) ? '0 : cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign cnt_nx_o = cnt_d;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ratio_i);
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
  parameter int unsigned CODE_W = clkdiv_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic [CODE_W-1:0] phase_code_i,
  input  logic              apply_i,
  input  logic              sync_i,
  output logic              div_en_o,
  output logic              div_clk_o,
  output logic              stab_active_o
);
  logic [CODE_W-1:0] ratio_q, ratio_nx, load_phase, cnt_q, cnt_nx;
  logic              restart, dly_zero, dly_zero_nx, clk_d, clk_q;

  clkdiv_cfg #(.CODE_W(CODE_W)) i_cfg (
    .clk_i, .rst_ni, .ratio_code_i, .phase_code_i, .apply_i, .sync_i,
    .ratio_o(ratio_q), .ratio_nx_o(ratio_nx), .load_phase_o(load_phase),
    .restart_o(restart), .stab_o(stab_active_o)
  );

  clkdiv_delay #(.CODE_W(CODE_W)) i_delay (
    .clk_i, .rst_ni, .restart_i(restart), .load_i(load_phase),
    .zero_o(dly_zero), .zero_nx_o(dly_zero_nx)
  );

  clkdiv_count #(.CODE_W(CODE_W)) i_count (
    .clk_i, .rst_ni, .restart_i(restart), .adv_i(dly_zero),
    .ratio_i(ratio_q), .cnt_o(cnt_q), .cnt_nx_o(cnt_nx)
  );

  assign clk_d = dly_zero_nx &&
                 (int'(cnt_nx) < int'(clkdiv_pkg::high_len(int'(ratio_nx))));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b1;
    else         clk_q <= clk_d;
  end

  assign div_clk_o = clk_q;
  assign div_en_o  = dly_zero && (cnt_q == '0);

  // R8
  en_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o |-> div_clk_o);

  // R9
  no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && phase_code_i != '0) |=> !div_en_o && !div_clk_o);

  // R3
  stab_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> stab_active_o == ($past(ratio_code_i) != '0));

  // R7
  div1_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_en_o && ratio_q == '0 && !restart) |=> div_en_o);

  // R1
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_en_o && ratio_q != '0 && !restart) |=> !div_en_o);
endmodule

// File: tb/test_clkdiv_phase.sv
module test_clkdiv_phase;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ratio_code_i = '0, phase_code_i = '0;
  logic       apply_i = 1'b0, sync_i = 1'b0;
  logic       div_en_o, div_clk_o, stab_active_o;

  int checks = 0, failures = 0;
  bit done = 0;
  // reference state: cycles since last restart, active N and P
  int m_age = 0, m_n = 1, m_p = 0;

  always #5 clk_i = ~clk_i;

  clkdiv_phase i_clkdiv_phase (.*);

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", what, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic e_en, e_clk;
    e_en  = (m_age >= m_p) && (((m_age - m_p) % m_n) == 0);
    e_clk = (m_age >= m_p) && (((m_age - m_p) % m_n) < (m_n + 1) / 2);
    chk(div_en_o,      e_en,       "R1 R2 R7 en");
    chk(div_clk_o,     e_clk,      "R8 divclk");
    chk(stab_active_o, (m_n != 1), "R3 stab");
  endtask

  // one clock: inputs already set, model updated at edge, compare at negedge
  task automatic tick(input bit ap, input bit sy, input int r, input int p);
    apply_i = ap; sync_i = sy;
    ratio_code_i = 3'(r); phase_code_i = 3'(p);
    @(posedge clk_i);
    if (ap) begin m_n = r + 1; m_p = p; m_age = 0; end
    else if (sy) m_age = 0;
    else m_age++;
    @(negedge clk_i);
    apply_i = 0; sync_i = 0;
    compare();
  endtask

  task automatic idle(input int n, input int r, input int p);
    for (int i = 0; i < n; i++) tick(0, 0, r, p);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    m_age = 1;
    // R4 reset state
    chk(div_en_o, 1'b1, "R4 en after reset");
    chk(div_clk_o, 1'b1, "R4 divclk after reset");
    chk(stab_active_o, 1'b0, "R4 stab after reset");
    idle(5, 0, 0);
    // R5 code wiggles without apply
    for (int i = 0; i < 12; i++) tick(0, 0, (i * 3) % 8, (i * 5) % 8);
    // R6 apply: ratio 3 phase 2
    tick(1, 0, 2, 2);
    idle(20, 7, 7);
    // R6 sync mid-period
    tick(0, 1, 0, 0);
    idle(15, 0, 0);
    // R9 apply ratio 4 phase 5 in middle of a period
    tick(1, 0, 3, 5);
    idle(3, 0, 0);
    tick(1, 0, 7, 7);
    idle(30, 0, 0);
    // R7 divide by 1 with delay
    tick(1, 0, 0, 3);
    idle(10, 0, 0);
    // R10 sync and apply together
    tick(1, 1, 4, 1);
    idle(15, 0, 0);
    // R1 R2 R8 sweep
    for (int r = 0; r < 8; r++)
      for (int p = 0; p < 8; p++) begin
        tick(1, 0, r, p);
        idle(18, 7 - r, 7 - p);
        tick(0, 1, 7 - r, p);
        idle(6, 0, 0);
      end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule